// File: doc/BRIEF.md
# Masked Control Register Bank

This block is a bank of thirty-two 64-bit control register slots for a processor core, reached by a 5-bit index through one read port and one write port that may both be used in the same cycle. Each slot follows its own rule. Some keep every bit. Some keep only a fixed set of bits. Two are cleared by any write. Some may only be read and some may only be written. The remaining indices are undefined. An access that breaks a slot's rule, or that names an undefined index, raises a fault flag and changes nothing.

One slot holds a cycle counter. Its upper half comes from the stored value and its lower half from a free-running counter that starts at zero on reset. Two write-only slots do not store data. A write to either of them issues a one-cycle action pulse with a code, which the translation buffers use to invalidate their entries. Hardware sets bits in the exception summary and exception mask slots through set inputs.

Read results and faults are registered and appear in the cycle after the request. A read sees the contents as they were before a write issued in the same cycle.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset every slot reads as zero, and rd_data, rd_fault, wr_fault, act_pulse and act_code are all zero.
- R2: Slots 0 to 4 are full-width read/write and keep all 64 written bits.
- R3: Writes are masked per slot, and only the masked bits are kept:
  - 6 and 7 keep 0xf.
  - 8 keeps 0x18.
  - 10 keeps 0x7fff0.
  - 11 keeps 0xff_ffff_0300.
  - 12 and 13 keep 0xffff_ffff_c000_0000.
  - 14 keeps 0x1ffb.
  - 15 and 16 keep 0x3f.
  - 17 keeps 0x7f0.
  - 18 keeps 0xfe00_0000_0000_0000.
- R4: A write to slot 19 (exception summary) or slot 20 (exception mask) clears that slot whatever the data. Bits given on exc_sum_set or exc_mask_set in the same cycle are still set afterwards.
- R5: Slots 21 to 24 are read-only. A read returns zero without a fault, and a write raises wr_fault.
- R6: Slots 25 to 30 are write-only. A write is accepted without a fault, and a read raises rd_fault.
- R7: Indices 9 and 31 are undefined, and both a read and a write to them raise the fault flag of that port.
- R8: A faulting read returns zero on rd_data, and a faulting write leaves every slot unchanged.
- R9: A read of slot 5 (cycle counter) returns the stored bits 63:32 with the live counter in bits 31:0. The live counter advances by one every cycle, and a write to slot 5 stores all 64 bits.
- R10: A write to slot 29 gives act_pulse for exactly the next cycle with act_code 1. A write to slot 30 gives the same with act_code 2. Otherwise act_pulse is 0 and act_code is 0.
- R11: rd_data, rd_fault and wr_fault reflect the request of the previous cycle. A read returns the value held before a write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Read slot index |
| rd_data | output | 64 | Read result, one cycle later |
| rd_fault | output | 1 | Read broke the slot rule or used an undefined index |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write slot index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Write broke the slot rule or used an undefined index |
| exc_sum_set | input | 64 | Hardware bits OR-ed into slot 19 |
| exc_mask_set | input | 64 | Hardware bits OR-ed into slot 20 |
| act_pulse | output | 1 | One-cycle invalidate action |
| act_code | output | 2 | Action code: 1 = invalidate all, 2 = invalidate per process |

## Verification
Two events can meet on the exception summary and mask slots in one cycle: a software write that clears the slot, and hardware set bits arriving on the set inputs. The bench issues both together in directed steps. It then reads the slot back and expects exactly the set bits, with nothing left over from before the clear. The random phase also drives sparse set bits while writes land on slots 19 and 20. A second meeting point is a read and a write to the same slot in one cycle. There the bench expects the old value.

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [4:0]  rd_idx,
  output logic [63:0] rd_data,
  output logic        rd_fault,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [63:0] wr_data,
  output logic        wr_fault,
  input  logic [63:0] exc_sum_set,
  input  logic [63:0] exc_mask_set,
  output logic        act_pulse,
  output logic [1:0]  act_code
);
  localparam int NSLOT = 32;
  localparam logic [4:0] CYC = 5'd5, XSUM = 5'd19, XMSK = 5'd20, INV_ALL = 5'd29, INV_PRC = 5'd30;

  logic [63:0]      bank [NSLOT];
  logic [CNT_W-1:0] live;

  function automatic logic [63:0] keep(input logic [4:0] i);
    case (i)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5: keep = '1;
      5'd6, 5'd7:   keep = 64'hf;
      5'd8:         keep = 64'h18;
      5'd10:        keep = 64'h7fff0;
      5'd11:        keep = 64'hff_ffff_0300;
      5'd12, 5'd13: keep = 64'hffff_ffff_c000_0000;
      5'd14:        keep = 64'h1ffb;
      5'd15, 5'd16: keep = 64'h3f;
      5'd17:        keep = 64'h7f0;
      5'd18:        keep = 64'hfe00_0000_0000_0000;
      default:      keep = '0;
    endcase
  endfunction

  function automatic logic can_rd(input logic [4:0] i);
    can_rd = (i <= 5'd24) && (i != 5'd9);
  endfunction

  function automatic logic can_wr(input logic [4:0] i);
    can_wr = (i <= 5'd30) && (i != 5'd9) && !(i >= 5'd21 && i <= 5'd24);
  endfunction

  wire rd_ok = rd_en && can_rd(rd_idx);
  wire wr_ok = wr_en && can_wr(wr_idx);
  wire [63:0] rd_val = (rd_idx == CYC) ? {bank[CYC][63:CNT_W], live} : bank[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NSLOT; k++) bank[k] <= '0;
      live      <= '0;
      rd_data   <= '0;
      rd_fault  <= 1'b0;
      wr_fault  <= 1'b0;
      act_pulse <= 1'b0;
      act_code  <= 2'd0;
    end else begin
      live <= live + 1'b1;
      if (wr_ok) bank[wr_idx] <= wr_data & keep(wr_idx);
      bank[XSUM] <= ((wr_en && wr_idx == XSUM) ? 64'd0 : bank[XSUM]) | exc_sum_set;
      bank[XMSK] <= ((wr_en && wr_idx == XMSK) ? 64'd0 : bank[XMSK]) | exc_mask_set;
      rd_data   <= rd_ok ? rd_val : 64'd0;
      rd_fault  <= rd_en && !rd_ok;
      wr_fault  <= wr_en && !wr_ok;
      act_pulse <= wr_en && (wr_idx == INV_ALL || wr_idx == INV_PRC);
      act_code  <= !wr_en ? 2'd0 : (wr_idx == INV_ALL) ? 2'd1 : (wr_idx == INV_PRC) ? 2'd2 : 2'd0;
    end
  end

  assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> rd_data == 64'd0);

  assert_bad_write_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> (bank[0] == $past(bank[0]) && bank[6] == $past(bank[6]) &&
                  bank[18] == $past(bank[18]) && bank[21] == $past(bank[21])));

  assert_clear_then_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_idx) == XSUM) |-> bank[XSUM] == $past(exc_sum_set));

  assert_pulse_coded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> (act_code != 2'd0 && $past(wr_en)));

  assert_no_code_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_pulse |-> act_code == 2'd0);

  always @(posedge clk) begin
    if (rst_n) begin
      assert_trap_mask_R3: assert (bank[6][63:4] == '0 && bank[7][63:4] == '0);
      assert_ro_zero_R5: assert (bank[21] == '0 && bank[24] == '0);
    end
  end
endmodule

// File: tb/ctrl_reg_bank_tb.sv
module ctrl_reg_bank_tb_top;
  logic clk = 0, rst_n = 0;
  logic rd_en = 0, wr_en = 0;
  logic [4:0] rd_idx = 0, wr_idx = 0;
  logic [63:0] wr_data = 0, exc_sum_set = 0, exc_mask_set = 0;
  logic [63:0] rd_data;
  logic rd_fault, wr_fault, act_pulse;
  logic [1:0] act_code;
  int checks = 0, errors = 0;
  logic [63:0] m [32];
  logic [31:0] low_seen;

  always #5 clk = ~clk;

  ctrl_reg_bank dut_i (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_fault(rd_fault), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_fault(wr_fault),
    .exc_sum_set(exc_sum_set), .exc_mask_set(exc_mask_set), .act_pulse(act_pulse), .act_code(act_code));

  function automatic logic [63:0] mask_of(input int i);
    if (i <= 5) return '1;
    if (i == 6 || i == 7) return 64'hf;
    if (i == 8) return 64'h18;
    if (i == 10) return 64'h7fff0;
    if (i == 11) return 64'hff_ffff_0300;
    if (i == 12 || i == 13) return 64'hffff_ffff_c000_0000;
    if (i == 14) return 64'h1ffb;
    if (i == 15 || i == 16) return 64'h3f;
    if (i == 17) return 64'h7f0;
    if (i == 18) return 64'hfe00_0000_0000_0000;
    return 64'd0;
  endfunction
  function automatic bit readable(input int i);
    return !(i == 9 || i == 31 || (i >= 25 && i <= 30));
  endfunction
  function automatic bit writable(input int i);
    return !(i == 9 || i == 31 || (i >= 21 && i <= 24));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit re, input int ri, input bit we, input int wi,
                      input logic [63:0] wd, input logic [63:0] es, input logic [63:0] em);
    logic [63:0] e_rd; bit e_rf, e_wf, e_p; logic [1:0] e_c;
    e_rf = re && !readable(ri);
    e_rd = (re && !e_rf) ? m[ri] : 64'd0;
    e_wf = we && !writable(wi);
    e_p  = we && (wi == 29 || wi == 30);
    e_c  = !e_p ? 2'd0 : (wi == 29) ? 2'd1 : 2'd2;
    rd_en = re; rd_idx = 5'(ri); wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    exc_sum_set = es; exc_mask_set = em;
    if (we && writable(wi)) m[wi] = wd & mask_of(wi);
    m[19] = ((we && wi == 19) ? 64'd0 : m[19]) | es;
    m[20] = ((we && wi == 20) ? 64'd0 : m[20]) | em;
    @(posedge clk); @(negedge clk);
    rd_en = 0; wr_en = 0; exc_sum_set = 0; exc_mask_set = 0;
    if (re) begin
      if (ri == 5 && !e_rf) begin
        chk(rd_data[63:32] == e_rd[63:32], "R9 cycle upper", rd_data, e_rd);
        low_seen = rd_data[31:0];
      end else
        chk(rd_data == e_rd, e_rf ? "R8 faulting read / R6 R7" : "R11 R2 R3 R4 R5 read", rd_data, e_rd);
      chk(rd_fault == e_rf, "R5 R6 R7 rd_fault", 64'(rd_fault), 64'(e_rf));
    end
    if (we) chk(wr_fault == e_wf, "R5 R6 R7 wr_fault", 64'(wr_fault), 64'(e_wf));
    chk(act_pulse == e_p && act_code == e_c, "R10 action", {act_pulse, act_code}, {e_p, e_c});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] l1;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk(rd_data == 0 && !rd_fault && !wr_fault && !act_pulse && act_code == 0, "R1 reset outputs", rd_data, 0);
    for (int i = 0; i < 32; i++) if (readable(i) && i != 5) step(1, i, 0, 0, 0, 0, 0);
    // R2 R3 full and masked writes with all-ones
    for (int i = 0; i < 19; i++) begin step(0, 0, 1, i, '1, 0, 0); step(1, i, 0, 0, 0, 0, 0); end
    // R4 collision: clear and set in one cycle
    step(0, 0, 0, 0, 0, 64'hffff_0000_0000_0000, 64'h00ff);
    step(0, 0, 1, 19, '1, 64'h0000_0000_0000_0a05, 0);
    step(1, 19, 1, 20, 64'h1234, 0, 64'h8000_0000_0000_0001);
    step(1, 20, 0, 0, 0, 0, 0);
    // R11 same-cycle read and write
    step(1, 2, 1, 2, 64'hdead_beef_0bad_f00d, 0, 0);
    step(1, 2, 0, 0, 0, 0, 0);
    // R5 R8 read-only write faults and keeps zero
    step(0, 0, 1, 22, '1, 0, 0);
    step(1, 22, 0, 0, 0, 0, 0);
    // R6 R7 R10
    step(1, 25, 1, 29, 5, 0, 0);
    step(1, 9, 1, 30, 5, 0, 0);
    step(1, 31, 1, 31, 5, 0, 0);
    step(0, 0, 1, 9, 5, 0, 0);
    // R9 live counter
    step(0, 0, 1, 5, 64'hcafe_f00d_0000_0000, 0, 0);
    step(1, 5, 0, 0, 0, 0, 0); l1 = low_seen;
    step(1, 5, 0, 0, 0, 0, 0);
    chk(low_seen == l1 + 1, "R9 live low consecutive", 64'(low_seen), 64'(l1 + 1));
    l1 = low_seen;
    repeat (4) step(0, 0, 0, 0, 0, 0, 0);
    step(1, 5, 0, 0, 0, 0, 0);
    chk(low_seen == l1 + 5, "R9 live low gap", 64'(low_seen), 64'(l1 + 5));
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [63:0] es, em;
      es = ($urandom % 4 == 0) ? (64'(1) << ($urandom % 64)) : 64'd0;
      em = ($urandom % 4 == 0) ? (64'(1) << ($urandom % 64)) : 64'd0;
      step($urandom % 2 == 0, int'($urandom % 32), $urandom % 2 == 0, int'($urandom % 32),
           {$urandom, $urandom}, es, em);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule